// File: doc/BRIEF.md
# SPI Transfer Buffer and Event Unit

This block sits between a simple register port and an SPI shift engine. Software queues outgoing words in a transmit queue and collects incoming words from a receive queue. Each queue holds eight 32-bit words. One address serves both directions: a write to it queues a transmit word, and a read from it removes the oldest received word. The shift engine takes transmit words and delivers receive words through a valid/take pair and a push strobe.

Software sets a fill threshold for each queue. It can flush either queue with a single write. A receive-not-empty status bit can be polled. The unit raises a maskable interrupt when the receive queue fills to its threshold, and another when a word arrives while the receive queue is already full. A global enable bit stops all engine traffic while it is low. Event flags are read and cleared through one shared address by writing ones.

Top module: `spi_fifo_irq_unit`

Register offsets (byte addresses): control 0x00, queue control 0x04, status 0x08, interrupt enable 0x0C, event flags/clear 0x10, data 0x14.

## Requirements
- R1: After reset both queues are empty, every register reads 0 except the event word, and irq and engTxValid are low. The event word reads 0x400 after reset, because bit 10 (transmit level) is set while the empty transmit queue is at or below its threshold of 0.
- R2: Writes to data (0x14) queue transmit words. While enabled, engTxValid is high and engTxData shows the oldest word, and each cycle with engTxTake high removes that word. A write made while 8 words are already queued is dropped.
- R3: Each engine push stores engRxData. A read of data (0x14) returns the oldest stored word and removes it. A read of an empty queue returns 0. Status (0x08) bit 0 is 1 exactly when the receive queue is not empty.
- R4: Control (0x00) bit 0 is the enable bit. While it is 0, engTxValid stays low and engine pushes are ignored. Transmit words written during this time are kept.
- R5: Queue control (0x04) holds the transmit threshold in bits 11:8 and the receive threshold in bits 3:0, and both read back. Writing a 1 to bit 12 empties the transmit queue, and writing a 1 to bit 4 empties the receive queue. Bits 12 and 4 read as 0.
- R6: The receive-complete flag (event bit 3) sets when an accepted push, with no read in the same cycle, brings the receive count to the receive threshold. Event bit 9 reads 1 while the threshold is nonzero and the count is at or above it.
- R7: A push while 8 receive words are held drops the word and sets the overrun flag (event bit 0).
- R8: Writing to the event address (0x10) clears each flag whose bit is 1: bit 0 overrun, bit 3 receive-complete, bit 4 transmit-complete. Flags written with 0 keep their value.
- R9: irq = (overrun flag AND enable bit 0 of 0x0C) OR (receive-complete flag AND enable bit 3 of 0x0C).
- R10: The transmit-complete flag (event bit 4) sets when the engine takes the last queued transmit word. Event bit 10 reads 1 while the transmit count is at or below the transmit threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe (a read of data removes a word) |
| regAddr | input | 6 | Byte address |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data, combinational from regAddr |
| engTxValid | output | 1 | A transmit word is available to the engine |
| engTxData | output | 32 | Oldest transmit word |
| engTxTake | input | 1 | Engine takes the oldest transmit word |
| engRxPush | input | 1 | Engine delivers a received word |
| engRxData | input | 32 | Received word |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check on every cycle the following properties:
- queue counts stay within their bounds;
- a flush leaves the queue empty on the next cycle;
- a full-queue push raises overrun;
- a disabled unit never offers a transmit word;
- receive-complete rises only at the threshold count;
- irq stays low with both enables clear.

Data ordering, the dropping of words at full, the read-back of fields and the selective clearing of flags are shown only by the bench's directed scenarios, which compare the words and flag bits seen at the ports against values computed in the bench.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;
  localparam int OFF_CTRL  = 'h00;
  localparam int OFF_QCTL  = 'h04;
  localparam int OFF_STAT  = 'h08;
  localparam int OFF_IEN   = 'h0C;
  localparam int OFF_EVT   = 'h10;
  localparam int OFF_DATA  = 'h14;

  typedef struct packed {
    logic txPush;
    logic txPop;
    logic txFlush;
    logic rxPush;
    logic rxPop;
    logic rxFlush;
  } fifoStrobes_t;
endpackage

// File: rtl/spi_fifo_buf.sv
module spi_fifo_buf #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 8,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic             pop,
  input  logic             flush,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] head,
  output logic [CW-1:0]    count,
  output logic             empty,
  output logic             full
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0] wrPtr, rdPtr;
  logic doPush, doPop;

  assign empty  = (count == '0);
  assign full   = (int'(count) == DEPTH);
  assign doPush = push && !full;
  assign doPop  = pop && !empty;
  assign head   = mem[rdPtr];

  function automatic logic [PW-1:0] nextPtr(input logic [PW-1:0] p);
    return (int'(p) == DEPTH - 1) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (doPush && !flush) mem[wrPtr] <= wdata;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      case ({doPush, doPop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  a_r2_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    int'(count) <= DEPTH);
  a_r5_flush_empties: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> empty);
  a_r7_full_holds: assert property (@(posedge clk) disable iff (!rstN)
    (full && push && !pop && !flush) |=> full);
endmodule

// File: rtl/spi_fifo_dp.sv
module spi_fifo_dp
  import spi_fifo_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  fifoStrobes_t      stb,
  input  logic [DATA_W-1:0] txWdata,
  input  logic [DATA_W-1:0] rxWdata,
  output logic [DATA_W-1:0] txHead,
  output logic [DATA_W-1:0] rxHead,
  output logic [CW-1:0]     txCount,
  output logic [CW-1:0]     rxCount,
  output logic              txEmpty,
  output logic              rxEmpty,
  output logic              rxFull
);
  logic txFullUnused;

  spi_fifo_buf #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rstN(rstN), .push(stb.txPush), .pop(stb.txPop),
    .flush(stb.txFlush), .wdata(txWdata), .head(txHead),
    .count(txCount), .empty(txEmpty), .full(txFullUnused));

  spi_fifo_buf #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rstN(rstN), .push(stb.rxPush), .pop(stb.rxPop),
    .flush(stb.rxFlush), .wdata(rxWdata), .head(rxHead),
    .count(rxCount), .empty(rxEmpty), .full(rxFull));
endmodule

// File: rtl/spi_fifo_ctl.sv
module spi_fifo_ctl
  import spi_fifo_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 6,
  parameter int DEPTH  = 8,
  parameter int THR_W  = 4,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic              engTxTake,
  input  logic              engRxPush,
  output logic              engTxValid,
  input  logic [DATA_W-1:0] rxHead,
  input  logic [CW-1:0]     txCount,
  input  logic [CW-1:0]     rxCount,
  input  logic              txEmpty,
  input  logic              rxEmpty,
  input  logic              rxFull,
  output fifoStrobes_t      stb,
  output logic              irq
);
  logic enable;
  logic [THR_W-1:0] txThr, rxThr;
  logic ienOvr, ienRc;
  logic flagOvr, flagRc, flagTc;
  logic selCtrl, selQctl, selStat, selIen, selEvt, selData;
  logic rxLevel, txLevel, ovrSet, rcSet, tcSet;
  logic unusedWdata;

  assign unusedWdata = ^regWdata;

  assign selCtrl = (regAddr == ADDR_W'(OFF_CTRL));
  assign selQctl = (regAddr == ADDR_W'(OFF_QCTL));
  assign selStat = (regAddr == ADDR_W'(OFF_STAT));
  assign selIen  = (regAddr == ADDR_W'(OFF_IEN));
  assign selEvt  = (regAddr == ADDR_W'(OFF_EVT));
  assign selData = (regAddr == ADDR_W'(OFF_DATA));

  // strobes toward the datapath; engine traffic is gated by enable (R4)
  always_comb begin
    stb.txPush  = regWr && selData;
    stb.txFlush = regWr && selQctl && regWdata[12];
    stb.rxPop   = regRd && selData;
    stb.rxFlush = regWr && selQctl && regWdata[4];
    stb.rxPush  = engRxPush && enable;
    stb.txPop   = engTxTake && engTxValid;
  end

  assign engTxValid = enable && !txEmpty;

  assign rxLevel = (rxThr != '0) && (int'(rxCount) >= int'(rxThr));
  assign txLevel = int'(txCount) <= int'(txThr);
  assign ovrSet  = stb.rxPush && rxFull;
  assign rcSet   = stb.rxPush && !rxFull && !(stb.rxPop && !rxEmpty) &&
                   !stb.rxFlush && (int'(rxCount) + 1 == int'(rxThr));
  assign tcSet   = stb.txPop && (int'(txCount) == 1) && !stb.txPush && !stb.txFlush;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enable  <= 1'b0;
      txThr   <= '0;
      rxThr   <= '0;
      ienOvr  <= 1'b0;
      ienRc   <= 1'b0;
      flagOvr <= 1'b0;
      flagRc  <= 1'b0;
      flagTc  <= 1'b0;
    end else begin
      if (regWr && selCtrl) enable <= regWdata[0];
      if (regWr && selQctl) begin
        txThr <= regWdata[8 +: THR_W];
        rxThr <= regWdata[0 +: THR_W];
      end
      if (regWr && selIen) begin
        ienRc  <= regWdata[3];
        ienOvr <= regWdata[0];
      end
      // set takes priority over a same-cycle clear (R8)
      flagOvr <= (flagOvr && !(regWr && selEvt && regWdata[0])) || ovrSet;
      flagRc  <= (flagRc  && !(regWr && selEvt && regWdata[3])) || rcSet;
      flagTc  <= (flagTc  && !(regWr && selEvt && regWdata[4])) || tcSet;
    end
  end

  assign irq = (flagOvr && ienOvr) || (flagRc && ienRc);

  always_comb begin
    regRdata = '0;
    if (selCtrl) regRdata[0] = enable;
    if (selQctl) begin
      regRdata[8 +: THR_W] = txThr;
      regRdata[0 +: THR_W] = rxThr;
    end
    if (selStat) regRdata[0] = !rxEmpty;
    if (selIen) begin
      regRdata[3] = ienRc;
      regRdata[0] = ienOvr;
    end
    if (selEvt) begin
      regRdata[10] = txLevel;
      regRdata[9]  = rxLevel;
      regRdata[4]  = flagTc;
      regRdata[3]  = flagRc;
      regRdata[0]  = flagOvr;
    end
    if (selData && !rxEmpty) regRdata = rxHead;
  end

  a_r4_no_offer_when_off: assert property (@(posedge clk) disable iff (!rstN)
    !enable |-> !engTxValid);
  a_r7_overrun_flag: assert property (@(posedge clk) disable iff (!rstN)
    (engRxPush && enable && rxFull) |=> flagOvr);
  a_r6_rc_at_threshold: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(flagRc) && $stable(rxThr)) |-> (int'(rxCount) == int'(rxThr)));
  a_r9_irq_masked: assert property (@(posedge clk) disable iff (!rstN)
    (!ienOvr && !ienRc) |-> !irq);
endmodule

// File: rtl/spi_fifo_irq_unit.sv
module spi_fifo_irq_unit
  import spi_fifo_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 6,
  parameter int DEPTH  = 8,
  parameter int THR_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic              engTxValid,
  output logic [DATA_W-1:0] engTxData,
  input  logic              engTxTake,
  input  logic              engRxPush,
  input  logic [DATA_W-1:0] engRxData,
  output logic              irq
);
  localparam int CW = $clog2(DEPTH + 1);

  fifoStrobes_t stb;
  logic [DATA_W-1:0] rxHead;
  logic [CW-1:0] txCount, rxCount;
  logic txEmpty, rxEmpty, rxFull;

  spi_fifo_ctl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .DEPTH(DEPTH), .THR_W(THR_W)) u_ctl (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regRd(regRd), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .engTxTake(engTxTake),
    .engRxPush(engRxPush), .engTxValid(engTxValid), .rxHead(rxHead),
    .txCount(txCount), .rxCount(rxCount), .txEmpty(txEmpty), .rxEmpty(rxEmpty),
    .rxFull(rxFull), .stb(stb), .irq(irq));

  spi_fifo_dp #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .txWdata(regWdata), .rxWdata(engRxData),
    .txHead(engTxData), .rxHead(rxHead), .txCount(txCount), .rxCount(rxCount),
    .txEmpty(txEmpty), .rxEmpty(rxEmpty), .rxFull(rxFull));
endmodule

// File: tb/spi_fifo_irq_unit_bench.sv
module spi_fifo_irq_unit_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWr = 1'b0, regRd = 1'b0;
  logic [5:0] regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic engTxValid;
  logic [31:0] engTxData;
  logic engTxTake = 1'b0, engRxPush = 1'b0;
  logic [31:0] engRxData = '0;
  logic irq;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  spi_fifo_irq_unit u_spi_fifo_irq_unit (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regRd(regRd), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .engTxValid(engTxValid),
    .engTxData(engTxData), .engTxTake(engTxTake), .engRxPush(engRxPush),
    .engRxData(engRxData), .irq(irq));

  localparam logic [5:0] A_CTRL = 6'h00, A_QCTL = 6'h04, A_STAT = 6'h08,
                         A_IEN = 6'h0C, A_EVT = 6'h10, A_DATA = 6'h14;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); regWr = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk); regWr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); regRd = 1'b1; regAddr = a;
    #1 d = regRdata;
    @(negedge clk); regRd = 1'b0;
  endtask

  task automatic epush(input logic [31:0] d);
    @(negedge clk); engRxPush = 1'b1; engRxData = d;
    @(negedge clk); engRxPush = 1'b0;
  endtask

  task automatic etake(output logic [31:0] d);
    @(negedge clk); d = engTxData; engTxTake = 1'b1;
    @(negedge clk); engTxTake = 1'b0;
  endtask

  task automatic clean();
    wr(A_QCTL, 32'h1010);
    wr(A_EVT, 32'h19);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(A_CTRL, v); check("R1 ctrl", v, 0);
    rd(A_QCTL, v); check("R1 qctl", v, 0);
    rd(A_STAT, v); check("R1 stat", v, 0);
    rd(A_IEN, v);  check("R1 ien", v, 0);
    rd(A_EVT, v);  check("R1 evt", v, 32'h400);
    check("R1 irq", irq, 0);
    check("R1 txvalid", engTxValid, 0);
  endtask

  task automatic t_tx_order();
    logic [31:0] v;
    wr(A_CTRL, 1);
    for (int i = 0; i < 3; i++) wr(A_DATA, 32'hC0DE_0000 + i);
    for (int i = 0; i < 3; i++) begin
      check("R2 valid", engTxValid, 1);
      etake(v); check("R2 order", v, 32'hC0DE_0000 + i);
    end
    check("R2 drained", engTxValid, 0);
    for (int i = 0; i < 9; i++) wr(A_DATA, 32'hA000_0000 + i);
    for (int i = 0; i < 8; i++) begin
      etake(v); check("R2 full order", v, 32'hA000_0000 + i);
    end
    check("R2 ninth dropped", engTxValid, 0);
    clean();
  endtask

  task automatic t_rx();
    logic [31:0] v;
    epush(32'h1111_2222); epush(32'h3333_4444);
    rd(A_STAT, v); check("R3 not empty", v, 1);
    rd(A_DATA, v); check("R3 first", v, 32'h1111_2222);
    rd(A_DATA, v); check("R3 second", v, 32'h3333_4444);
    rd(A_STAT, v); check("R3 empty", v, 0);
    rd(A_DATA, v); check("R3 empty read", v, 0);
  endtask

  task automatic t_gate();
    logic [31:0] v;
    wr(A_CTRL, 0);
    wr(A_DATA, 32'h5555_AAAA);
    check("R4 no offer", engTxValid, 0);
    epush(32'h7777_7777);
    rd(A_STAT, v); check("R4 push ignored", v, 0);
    wr(A_CTRL, 1);
    check("R4 kept word", engTxData, 32'h5555_AAAA);
    check("R4 offer after enable", engTxValid, 1);
  endtask

  task automatic t_flush();
    logic [31:0] v;
    wr(A_QCTL, 32'h1000);
    check("R5 tx flush", engTxValid, 0);
    epush(1); epush(2);
    wr(A_QCTL, 32'h0010);
    rd(A_STAT, v); check("R5 rx flush", v, 0);
    wr(A_QCTL, 32'h1513);
    rd(A_QCTL, v); check("R5 thresholds", v, 32'h0503);
    clean();
  endtask

  task automatic t_rc();
    logic [31:0] v;
    wr(A_QCTL, 32'h0003);
    wr(A_IEN, 32'h8);
    epush(10); epush(11);
    rd(A_EVT, v); check("R6 below thr flag", v[3], 0); check("R6 below level", v[9], 0);
    check("R9 irq low", irq, 0);
    epush(12);
    rd(A_EVT, v); check("R6 flag at thr", v[3], 1); check("R6 level at thr", v[9], 1);
    check("R9 irq rc", irq, 1);
    rd(A_DATA, v);
    rd(A_EVT, v); check("R6 level drops", v[9], 0); check("R6 flag sticks", v[3], 1);
    clean();
  endtask

  task automatic t_ovr();
    logic [31:0] v;
    wr(A_IEN, 32'h1);
    for (int i = 0; i < 9; i++) epush(32'hB000_0000 + i);
    rd(A_EVT, v); check("R7 overrun flag", v[0], 1);
    check("R9 irq ovr", irq, 1);
    for (int i = 0; i < 8; i++) begin
      rd(A_DATA, v); check("R7 kept order", v, 32'hB000_0000 + i);
    end
    rd(A_STAT, v); check("R7 ninth dropped", v, 0);
  endtask

  task automatic t_clr();
    logic [31:0] v;
    wr(A_QCTL, 32'h0011);
    epush(5);
    rd(A_EVT, v); check("R8 both set", {v[3], v[0]}, 2'b11);
    wr(A_EVT, 32'h8);
    rd(A_EVT, v); check("R8 rc cleared ovr kept", {v[3], v[0]}, 2'b01);
    wr(A_EVT, 32'h1);
    rd(A_EVT, v); check("R8 ovr cleared", v[0], 0);
    clean();
  endtask

  task automatic t_irq();
    for (int i = 0; i < 9; i++) epush(i);
    wr(A_IEN, 0); check("R9 masked", irq, 0);
    wr(A_IEN, 1); check("R9 ovr enabled", irq, 1);
    wr(A_IEN, 8); check("R9 other enable", irq, 0);
    clean();
    wr(A_IEN, 0);
  endtask

  task automatic t_tc();
    logic [31:0] v;
    wr(A_QCTL, 32'h0100);
    wr(A_DATA, 1); wr(A_DATA, 2);
    rd(A_EVT, v); check("R10 level above", v[10], 0); check("R10 no tc", v[4], 0);
    etake(v);
    rd(A_EVT, v); check("R10 level at thr", v[10], 1); check("R10 not last", v[4], 0);
    etake(v);
    rd(A_EVT, v); check("R10 tc set", v[4], 1);
    wr(A_EVT, 32'h10);
    rd(A_EVT, v); check("R8 tc cleared", v[4], 0);
  endtask

  initial begin
    #(20 * 150000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_tx_order();
    t_rx();
    t_gate();
    t_flush();
    t_rc();
    t_ovr();
    t_clr();
    t_irq();
    t_tc();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule